// File: doc/BRIEF.md
# Dual-Channel Output Data Formatter

This block sits between the two conversion channels of a dual sampler and the output drivers. On every sample clock it takes one parallel sample per channel, in offset binary, and converts each to the selected number format. It then applies an optional bitwise inversion and a per-channel disable. Finally it places the two channels onto two output ports. For each sample clock it produces a word for the rising (clock-high) phase and a word for the falling (clock-low) phase, so that a DDR output stage can send both.

The channel-to-phase mapping depends on the electrical mode and the interleave setting. In differential mode everything goes out on port A. With interleave on, each channel gets one phase. With interleave off, the two channels are merged into one double-width word whose even bits go out on the rising phase and whose odd bits go out on the falling phase. In single-ended mode, interleave on gives DDR ports whose channel orderings mirror each other. Interleave off gives SDR, with one channel on each port. All outputs come from a single register stage.

Top module: `dual_out_formatter`

## Requirements
- R1: Every output is registered and reflects the inputs sampled on the previous rising clock edge. While rst_n is low, all port words are zero and both valid flags are low.
- R2: Format code 2'b00 passes the offset binary sample through unchanged. The reserved code 2'b11 behaves exactly like 2'b00.
- R3: Format code 2'b01 gives two's complement: the sample with only its most significant bit flipped.
- R4: Format code 2'b10 gives Gray code: the sample XOR the sample shifted right by one.
- R5: Inversion is applied after format conversion. inv_en bit 0 complements every bit of channel A and bit 1 complements channel B.
- R6: dis_en bit 0 (channel A) or bit 1 (channel B) forces that channel's contribution to all output slots to zero, inversion included, and drives its valid flag low. A channel that is not disabled has its valid flag follow in_valid.
- R7: Differential mode with interleave on: port_a_rise carries channel A, port_a_fall carries channel B, and port B is all zeros.
- R8: Differential mode with interleave off: form C = {B, A} (A in the low W bits). Bit i of port_a_rise is C[2i] and bit i of port_a_fall is C[2i+1]. Port B is all zeros.
- R9: Single-ended mode with interleave on: port A carries B when rising and A when falling. Port B carries A when rising and B when falling.
- R10: Single-ended mode with interleave off (SDR): both phases of port A carry A and both phases of port B carry B.
- R11: logic_type 2'b10 and 2'b11 select differential mode and give identical data. 2'b00 selects single-ended mode, and the unused code 2'b01 behaves like 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Samples on this clock are valid |
| samp_a | input | W | Channel A sample, offset binary |
| samp_b | input | W | Channel B sample, offset binary |
| fmt_sel | input | 2 | Number format code |
| inv_en | input | 2 | Per-channel invert (bit 0 = A, bit 1 = B) |
| dis_en | input | 2 | Per-channel disable (bit 0 = A, bit 1 = B) |
| logic_type | input | 2 | Electrical mode code |
| interleave | input | 1 | Interleave enable |
| port_a_rise | output | W | Port A, clock-high phase word |
| port_a_fall | output | W | Port A, clock-low phase word |
| port_b_rise | output | W | Port B, clock-high phase word |
| port_b_fall | output | W | Port B, clock-low phase word |
| valid_a | output | 1 | Channel A output valid |
| valid_b | output | 1 | Channel B output valid |

## Verification
The block holds no state beyond its one output register. A wrong internal value therefore shows up at the ports one clock after the offending inputs, and it disappears once the inputs change. A swapped phase or a swapped port shows as mirrored words in the interleaved modes. An off-by-one in the even/odd split garbles the merged differential word in a pattern that distinct per-channel samples expose. A format or inversion error alters the bit pattern in a way that depends on the sample value, so several asymmetric samples are applied in every mode.

// File: rtl/ofmt_pkg.sv
package ofmt_pkg;

    typedef enum logic [1:0] {
        FMT_OBIN = 2'b00,
        FMT_TWOS = 2'b01,
        FMT_GRAY = 2'b10,
        FMT_RSVD = 2'b11
    } num_fmt_e;

    localparam int NCH  = 2;
    localparam int CH_A = 0;
    localparam int CH_B = 1;

endpackage

// File: rtl/ofmt_chan_conv.sv
module ofmt_chan_conv
    import ofmt_pkg::*;
#(
    parameter int W = 10
) (
    input  logic [W-1:0] samp,
    input  num_fmt_e     fmt,
    input  logic         inv,
    input  logic         dis,
    output logic [W-1:0] word
);
    localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] conv_w;
    logic [W-1:0] inv_w;

    always_comb begin
        unique case (fmt)
            FMT_TWOS: conv_w = samp ^ MSB_MASK;
            FMT_GRAY: conv_w = samp ^ (samp >> 1);
            default:  conv_w = samp;
        endcase
        inv_w = inv ? ~conv_w : conv_w;
        word  = dis ? '0 : inv_w;
    end

endmodule

// File: rtl/ofmt_lane_map.sv
module ofmt_lane_map #(
    parameter int W = 10
) (
    input  logic [W-1:0] ch_a,
    input  logic [W-1:0] ch_b,
    input  logic [1:0]   logic_type,
    input  logic         interleave,
    output logic [W-1:0] a_rise,
    output logic [W-1:0] a_fall,
    output logic [W-1:0] b_rise,
    output logic [W-1:0] b_fall
);
    localparam int CW = 2 * W;

    logic [CW-1:0] merged;
    logic [W-1:0]  even_w;
    logic [W-1:0]  odd_w;
    logic          diff_mode;

    assign merged = {ch_b, ch_a};

    for (genvar i = 0; i < W; i++) begin : g_split
        assign even_w[i] = merged[2*i];
        assign odd_w[i]  = merged[2*i+1];
    end

    always_comb begin
        unique case (logic_type)
            2'b10, 2'b11: diff_mode = 1'b1;
            default:      diff_mode = 1'b0;
        endcase
    end

    always_comb begin
        b_rise = '0;
        b_fall = '0;
        if (diff_mode) begin
            if (interleave) begin
                a_rise = ch_a;
                a_fall = ch_b;
            end else begin
                a_rise = even_w;
                a_fall = odd_w;
            end
        end else if (interleave) begin
            a_rise = ch_b;
            a_fall = ch_a;
            b_rise = ch_a;
            b_fall = ch_b;
        end else begin
            a_rise = ch_a;
            a_fall = ch_a;
            b_rise = ch_b;
            b_fall = ch_b;
        end
    end

endmodule

// File: rtl/dual_out_formatter.sv
module dual_out_formatter
    import ofmt_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] samp_a,
    input  logic [W-1:0] samp_b,
    input  logic [1:0]   fmt_sel,
    input  logic [1:0]   inv_en,
    input  logic [1:0]   dis_en,
    input  logic [1:0]   logic_type,
    input  logic         interleave,
    output logic [W-1:0] port_a_rise,
    output logic [W-1:0] port_a_fall,
    output logic [W-1:0] port_b_rise,
    output logic [W-1:0] port_b_fall,
    output logic         valid_a,
    output logic         valid_b
);
    typedef struct packed {
        logic [W-1:0] ar;
        logic [W-1:0] af;
        logic [W-1:0] br;
        logic [W-1:0] bf;
        logic         va;
        logic         vb;
    } out_s;

    out_s out_d, out_q;

    logic [W-1:0] raw_w  [NCH];
    logic [W-1:0] chan_w [NCH];
    logic [W-1:0] ar_w, af_w, br_w, bf_w;

    assign raw_w[CH_A] = samp_a;
    assign raw_w[CH_B] = samp_b;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        ofmt_chan_conv #(.W(W)) conv_i (
            .samp (raw_w[c]),
            .fmt  (num_fmt_e'(fmt_sel)),
            .inv  (inv_en[c]),
            .dis  (dis_en[c]),
            .word (chan_w[c])
        );
    end

    ofmt_lane_map #(.W(W)) map_i (
        .ch_a       (chan_w[CH_A]),
        .ch_b       (chan_w[CH_B]),
        .logic_type (logic_type),
        .interleave (interleave),
        .a_rise     (ar_w),
        .a_fall     (af_w),
        .b_rise     (br_w),
        .b_fall     (bf_w)
    );

    always_comb begin
        out_d    = out_q;
        out_d.ar = ar_w;
        out_d.af = af_w;
        out_d.br = br_w;
        out_d.bf = bf_w;
        out_d.va = in_valid & ~dis_en[CH_A];
        out_d.vb = in_valid & ~dis_en[CH_B];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign port_a_rise = out_q.ar;
    assign port_a_fall = out_q.af;
    assign port_b_rise = out_q.br;
    assign port_b_fall = out_q.bf;
    assign valid_a     = out_q.va;
    assign valid_b     = out_q.vb;

    // R6: a disabled channel never reports valid on the following clock
    assert_dis_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dis_en) == 2'b11 |-> (!valid_a && !valid_b));

    // R7 / R8: port B stays silent in differential mode
    assert_diff_portb_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(logic_type[1]) && $past(rst_n)) |-> (port_b_rise == '0 && port_b_fall == '0));

    // R10: SDR single-ended gives equal phase words on each port
    assert_sdr_equal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!logic_type[1] && !interleave) && $past(rst_n))
            |-> (port_a_rise == port_a_fall && port_b_rise == port_b_fall));

    // R9: interleaved single-ended ports are mirror images
    assert_ddr_mirror_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!logic_type[1] && interleave) && $past(rst_n))
            |-> (port_a_rise == port_b_fall && port_a_fall == port_b_rise));

    // R1: reset state of the register stage
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!valid_a && !valid_b && port_a_rise == '0));

endmodule

// File: tb/dual_out_formatter_tb.sv
module dual_out_formatter_tb_top;
    localparam int W = 10;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] samp_a = '0, samp_b = '0;
    logic [1:0]   fmt_sel = 2'b00, inv_en = 2'b00, dis_en = 2'b00, logic_type = 2'b00;
    logic         interleave = 1'b0;
    logic [W-1:0] port_a_rise, port_a_fall, port_b_rise, port_b_fall;
    logic         valid_a, valid_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_out_formatter #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .samp_a(samp_a), .samp_b(samp_b), .fmt_sel(fmt_sel),
        .inv_en(inv_en), .dis_en(dis_en), .logic_type(logic_type),
        .interleave(interleave),
        .port_a_rise(port_a_rise), .port_a_fall(port_a_fall),
        .port_b_rise(port_b_rise), .port_b_fall(port_b_fall),
        .valid_a(valid_a), .valid_b(valid_b)
    );

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Model from R2..R6
    function automatic logic [W-1:0] mconv(logic [W-1:0] x, logic [1:0] f, logic inv, logic dis);
        logic [W-1:0] y;
        case (f)
            2'b01:   y = {~x[W-1], x[W-2:0]};
            2'b10:   y = x ^ {1'b0, x[W-1:1]};
            default: y = x;
        endcase
        if (inv) y = ~y;
        if (dis) y = '0;
        return y;
    endfunction

    // Apply inputs, wait one clock, compare all ports against R7..R11 mapping
    task automatic apply(string req, logic [W-1:0] a, logic [W-1:0] b, logic [1:0] f,
                         logic [1:0] inv, logic [1:0] dis, logic [1:0] lt, logic il, logic v);
        logic [W-1:0] ca, cb, ear, eaf, ebr, ebf;
        logic [2*W-1:0] c;
        @(negedge clk);
        samp_a = a; samp_b = b; fmt_sel = f; inv_en = inv; dis_en = dis;
        logic_type = lt; interleave = il; in_valid = v;
        ca = mconv(a, f, inv[0], dis[0]);
        cb = mconv(b, f, inv[1], dis[1]);
        c = {cb, ca};
        ebr = '0; ebf = '0;
        if (lt[1]) begin
            if (il) begin ear = ca; eaf = cb; end
            else for (int i = 0; i < W; i++) begin ear[i] = c[2*i]; eaf[i] = c[2*i+1]; end
        end else if (il) begin
            ear = cb; eaf = ca; ebr = ca; ebf = cb;
        end else begin
            ear = ca; eaf = ca; ebr = cb; ebf = cb;
        end
        @(negedge clk);
        chk({req, " a_rise"}, port_a_rise, ear);
        chk({req, " a_fall"}, port_a_fall, eaf);
        chk({req, " b_rise"}, port_b_rise, ebr);
        chk({req, " b_fall"}, port_b_fall, ebf);
        chk({req, " valid_a"}, {{(W-1){1'b0}}, valid_a}, {{(W-1){1'b0}}, v & ~dis[0]});
        chk({req, " valid_b"}, {{(W-1){1'b0}}, valid_b}, {{(W-1){1'b0}}, v & ~dis[1]});
    endtask

    task automatic t_reset;
        @(negedge clk);
        in_valid = 1'b1; samp_a = 10'h3FF; samp_b = 10'h3FF;
        @(negedge clk);
        chk("R1 reset a_rise", port_a_rise, '0);
        chk("R1 reset b_fall", port_b_fall, '0);
        chk("R1 reset valid", {{(W-2){1'b0}}, valid_a, valid_b}, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_latency;
        apply("R1 base", 10'h155, 10'h0AA, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b1);
        samp_a = 10'h2C3;
        #1;
        chk("R1 latency hold", port_a_rise, 10'h155);
        @(negedge clk);
        chk("R1 latency update", port_a_rise, 10'h2C3);
    endtask

    task automatic t_formats;
        apply("R2 obin", 10'h2A5, 10'h13C, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b1);
        apply("R2 reserved", 10'h2A5, 10'h13C, 2'b11, 2'b00, 2'b00, 2'b00, 1'b0, 1'b1);
        apply("R3 twos", 10'h2A5, 10'h13C, 2'b01, 2'b00, 2'b00, 2'b00, 1'b0, 1'b1);
        apply("R4 gray", 10'h2A5, 10'h13C, 2'b10, 2'b00, 2'b00, 2'b00, 1'b0, 1'b1);
        apply("R4 gray2", 10'h3F0, 10'h001, 2'b10, 2'b00, 2'b00, 2'b00, 1'b1, 1'b1);
    endtask

    task automatic t_invert;
        apply("R5 invA twos", 10'h2A5, 10'h13C, 2'b01, 2'b01, 2'b00, 2'b00, 1'b0, 1'b1);
        apply("R5 invB gray", 10'h2A5, 10'h13C, 2'b10, 2'b10, 2'b00, 2'b00, 1'b0, 1'b1);
    endtask

    task automatic t_disable;
        apply("R6 disB", 10'h2A5, 10'h13C, 2'b00, 2'b10, 2'b10, 2'b00, 1'b0, 1'b1);
        apply("R6 disA ddr", 10'h2A5, 10'h13C, 2'b01, 2'b11, 2'b01, 2'b00, 1'b1, 1'b1);
        apply("R6 disA lvds", 10'h2A5, 10'h13C, 2'b00, 2'b01, 2'b01, 2'b10, 1'b0, 1'b1);
        apply("R6 novalid", 10'h2A5, 10'h13C, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0);
    endtask

    task automatic t_diff;
        apply("R7 lvds ilv", 10'h2A5, 10'h13C, 2'b00, 2'b00, 2'b00, 2'b10, 1'b1, 1'b1);
        apply("R8 lvds split", 10'h2A5, 10'h13C, 2'b00, 2'b00, 2'b00, 2'b10, 1'b0, 1'b1);
        apply("R8 lvds split2", 10'h001, 10'h200, 2'b01, 2'b00, 2'b00, 2'b10, 1'b0, 1'b1);
        apply("R11 lvds reduced", 10'h2A5, 10'h13C, 2'b00, 2'b00, 2'b00, 2'b11, 1'b0, 1'b1);
    endtask

    task automatic t_cmos;
        apply("R9 cmos ddr", 10'h2A5, 10'h13C, 2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 1'b1);
        apply("R10 cmos sdr", 10'h0F0, 10'h30F, 2'b10, 2'b00, 2'b00, 2'b00, 1'b0, 1'b1);
        apply("R11 code01 ddr", 10'h2A5, 10'h13C, 2'b00, 2'b00, 2'b00, 2'b01, 1'b1, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_latency();
        t_formats();
        t_invert();
        t_disable();
        t_diff();
        t_cmos();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule